// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is a single output cell of a programmable logic device. It collects product terms from an AND array. Some of those terms are its own, and some are lent by neighbouring cells. It ORs them into a primary sum and a secondary sum. An XOR stage sets the polarity of the primary sum. The result either goes straight to the pin or feeds a flip-flop whose behaviour is chosen from four types: D, T, JK and SR.

The clock of the flip-flop comes from one of two sources: a dedicated clock pin or a product term. Preset and clear are asynchronous and active-high, and each is gated by its own enable bits. One signal drives both the pin and the feedback path into the array. All configuration is held on static input bits, which a surrounding programming interface sets.

Top module: `pld_out_cell`

## Requirements
- R1: A lent term counts in a sum only when its `brw_lent` bit and its `cfg_brw_en` bit are both 1. Each counted term with `cfg_brw_sec` = 0 joins the primary sum, which is the OR of all `native_pt` bits and those counted terms.
- R2: The secondary sum is the OR of the counted lent terms whose `cfg_brw_sec` bit is 1. It drives K in JK mode and R in SR mode, and it never reaches the primary sum.
- R3: When `cfg_inv` = 1, the primary sum is inverted before it reaches the output mux and the flip-flop.
- R4: When `cfg_use_reg` = 0, `pin_out` equals the polarised primary sum combinationally. When `cfg_use_reg` = 1, `pin_out` equals the flip-flop state. `fb_out` always equals `pin_out`.
- R5: With `cfg_ff_type` = 2'b00 (D), the flop loads the polarised primary sum on each active clock edge.
- R6: With `cfg_ff_type` = 2'b01 (T), the flop toggles on an active edge when the polarised primary sum is 1, and holds otherwise.
- R7: With `cfg_ff_type` = 2'b10 (JK), J is the polarised primary sum and K is the secondary sum. J=1,K=0 sets; J=0,K=1 resets; J=K=1 toggles; J=K=0 holds.
- R8: With `cfg_ff_type` = 2'b11 (SR), S is the polarised primary sum and R is the secondary sum. S alone sets, R alone resets, and S=R=0 or S=R=1 both hold.
- R9: When `cfg_clk_sel` = 1, the flop is clocked on rising edges of `clk_pin` only. When `cfg_clk_sel` = 0, it is clocked on rising edges of `clk_pt` only.
- R10: When `pre_pt` = 1 and `cfg_pre_en` = 1, the state is set to 1 at once, without a clock. With `cfg_pre_en` = 0, `pre_pt` has no effect.
- R11: Clear is active when any `clr_pt[i]` with `cfg_clr_en[i]` = 1 is high. It forces the state to 0 at once, and it overrides an active preset.
- R12: While `por_n` = 0, the flip-flop state is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Dedicated clock pin |
| por_n | input | 1 | Power-on reset, active low, clears the state |
| native_pt | input | NATIVE_PT | Product terms owned by this cell |
| brw_pt | input | BRW_PT | Product terms offered by neighbouring cells |
| brw_lent | input | BRW_PT | Per-term flag: neighbour is not using the term |
| cfg_brw_en | input | BRW_PT | Per-term enable of borrowing |
| cfg_brw_sec | input | BRW_PT | Per-term route: 1 = secondary sum, 0 = primary sum |
| cfg_inv | input | 1 | Inverts the primary sum |
| cfg_use_reg | input | 1 | 1 = registered output, 0 = combinational output |
| cfg_ff_type | input | 2 | Flop type: 00 D, 01 T, 10 JK, 11 SR |
| cfg_clk_sel | input | 1 | 1 = clock from clk_pin, 0 = clock from clk_pt |
| clk_pt | input | 1 | Product-term clock |
| pre_pt | input | 1 | Preset product term |
| cfg_pre_en | input | 1 | Preset enable |
| clr_pt | input | CLR_PT | Clear product terms |
| cfg_clr_en | input | CLR_PT | Per-term clear enable |
| pin_out | output | 1 | Output to the pin |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
The hardest states to reach are the asynchronous ones. Examples are a preset and a clear that overlap, and a clear term that is masked while a preset holds the state at 1. The product-term clock raises a similar problem, because edges must fall between edges of the pin clock. The bench handles this by moving to the product-term clock while both clocks are low. It then raises `clk_pt`, `pre_pt` and `clr_pt` by hand a nanosecond after a falling edge of `clk_pin`, and its reference model applies each event at the moment it drives it. The secondary sum can only be seen through the JK and SR types. The bench reaches it by first presetting the state, and then routing a single lent term to the secondary side so that it resets the state.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  typedef enum logic [1:0] {
    FF_D  = 2'b00,
    FF_T  = 2'b01,
    FF_JK = 2'b10,
    FF_SR = 2'b11
  } ff_kind_e;

  // next state of the storage element for primary input a and secondary input b
  function automatic logic ff_next(input ff_kind_e kind, input logic q,
                                   input logic a, input logic b);
    logic r;
    unique case (kind)
      FF_D:  r = a;
      FF_T:  r = q ^ a;
      FF_JK: r = (a & ~q) | (~b & q);
      FF_SR: r = (a & ~b) | (q & ~(b & ~a));
      default: r = q;
    endcase
    return r;
  endfunction

  // a term counts when it is lent, enabled and routed to the requested side
  function automatic logic term_counts(input logic pt, input logic lent,
                                       input logic en, input logic sec,
                                       input logic want_sec);
    return pt & lent & en & (sec == want_sec);
  endfunction

endpackage

// File: rtl/pt_sum.sv
module pt_sum #(
  parameter int NATIVE_PT = 3,
  parameter int BRW_PT    = 6
) (
  input  logic [NATIVE_PT-1:0] native_pt,
  input  logic [BRW_PT-1:0]    brw_pt,
  input  logic [BRW_PT-1:0]    brw_lent,
  input  logic [BRW_PT-1:0]    cfg_brw_en,
  input  logic [BRW_PT-1:0]    cfg_brw_sec,
  output logic                 prim_raw,
  output logic                 sec_raw
);
  import pld_mc_pkg::*;

  logic [BRW_PT-1:0] to_prim;
  logic [BRW_PT-1:0] to_sec;

  for (genvar i = 0; i < BRW_PT; i++) begin : g_brw
    assign to_prim[i] = term_counts(brw_pt[i], brw_lent[i], cfg_brw_en[i],
                                    cfg_brw_sec[i], 1'b0);
    assign to_sec[i]  = term_counts(brw_pt[i], brw_lent[i], cfg_brw_en[i],
                                    cfg_brw_sec[i], 1'b1);
  end

  assign prim_raw = (|native_pt) | (|to_prim);
  assign sec_raw  = |to_sec;
endmodule

// File: rtl/async_ctl.sv
module async_ctl #(
  parameter int CLR_PT = 2
) (
  input  logic              clk_pin,
  input  logic              clk_pt,
  input  logic              cfg_clk_sel,
  input  logic              por_n,
  input  logic              pre_pt,
  input  logic              cfg_pre_en,
  input  logic [CLR_PT-1:0] clr_pt,
  input  logic [CLR_PT-1:0] cfg_clr_en,
  output logic              ff_clk,
  output logic              pre_act,
  output logic              clr_act
);
  assign ff_clk  = cfg_clk_sel ? clk_pin : clk_pt;
  assign pre_act = pre_pt & cfg_pre_en;
  assign clr_act = ~por_n | (|(clr_pt & cfg_clr_en));
endmodule

// File: rtl/ff_core.sv
module ff_core (
  input  logic                 ff_clk,
  input  logic                 pre_act,
  input  logic                 clr_act,
  input  pld_mc_pkg::ff_kind_e kind,
  input  logic                 a_in,
  input  logic                 b_in,
  output logic                 q
);
  import pld_mc_pkg::*;

  logic q_next;
  assign q_next = ff_next(kind, q, a_in, b_in);

  // clear outranks preset
  always_ff @(posedge ff_clk or posedge clr_act or posedge pre_act) begin
    if (clr_act)      q <= 1'b0;
    else if (pre_act) q <= 1'b1;
    else              q <= q_next;
  end
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell #(
  parameter int NATIVE_PT = 3,
  parameter int BRW_PT    = 6,
  parameter int CLR_PT    = 2
) (
  input  logic                 clk_pin,
  input  logic                 por_n,
  input  logic [NATIVE_PT-1:0] native_pt,
  input  logic [BRW_PT-1:0]    brw_pt,
  input  logic [BRW_PT-1:0]    brw_lent,
  input  logic [BRW_PT-1:0]    cfg_brw_en,
  input  logic [BRW_PT-1:0]    cfg_brw_sec,
  input  logic                 cfg_inv,
  input  logic                 cfg_use_reg,
  input  logic [1:0]           cfg_ff_type,
  input  logic                 cfg_clk_sel,
  input  logic                 clk_pt,
  input  logic                 pre_pt,
  input  logic                 cfg_pre_en,
  input  logic [CLR_PT-1:0]    clr_pt,
  input  logic [CLR_PT-1:0]    cfg_clr_en,
  output logic                 pin_out,
  output logic                 fb_out
);
  import pld_mc_pkg::*;

  logic     prim_raw;
  logic     sec_raw;
  logic     d_in;
  logic     ff_clk;
  logic     pre_act;
  logic     clr_act;
  logic     state_q;
  ff_kind_e kind;

  assign kind = ff_kind_e'(cfg_ff_type);

  pt_sum #(.NATIVE_PT(NATIVE_PT), .BRW_PT(BRW_PT)) u_sum (
    .native_pt   (native_pt),
    .brw_pt      (brw_pt),
    .brw_lent    (brw_lent),
    .cfg_brw_en  (cfg_brw_en),
    .cfg_brw_sec (cfg_brw_sec),
    .prim_raw    (prim_raw),
    .sec_raw     (sec_raw)
  );

  assign d_in = prim_raw ^ cfg_inv;

  async_ctl #(.CLR_PT(CLR_PT)) u_ctl (
    .clk_pin     (clk_pin),
    .clk_pt      (clk_pt),
    .cfg_clk_sel (cfg_clk_sel),
    .por_n       (por_n),
    .pre_pt      (pre_pt),
    .cfg_pre_en  (cfg_pre_en),
    .clr_pt      (clr_pt),
    .cfg_clr_en  (cfg_clr_en),
    .ff_clk      (ff_clk),
    .pre_act     (pre_act),
    .clr_act     (clr_act)
  );

  ff_core u_ff (
    .ff_clk  (ff_clk),
    .pre_act (pre_act),
    .clr_act (clr_act),
    .kind    (kind),
    .a_in    (d_in),
    .b_in    (sec_raw),
    .q       (state_q)
  );

  assign pin_out = cfg_use_reg ? state_q : d_in;
  assign fb_out  = pin_out;
endmodule

// File: rtl/pld_out_cell_chk.sv
module pld_out_cell_chk #(
  parameter int BRW_PT = 6
) (
  input logic              clk_pin,
  input logic              por_n,
  input logic              cfg_clk_sel,
  input logic [1:0]        cfg_ff_type,
  input logic              cfg_use_reg,
  input logic              pin_out,
  input logic              d_in,
  input logic              state_q,
  input logic              pre_act,
  input logic              clr_act,
  input logic              prim_raw,
  input logic [BRW_PT-1:0] brw_pt,
  input logic [BRW_PT-1:0] brw_lent,
  input logic [BRW_PT-1:0] cfg_brw_en,
  input logic [BRW_PT-1:0] cfg_brw_sec
);
  // R11
  clear_wins_chk: assert property (@(posedge clk_pin) disable iff (!por_n)
    clr_act |-> !state_q);

  // R10
  preset_sets_chk: assert property (@(posedge clk_pin) disable iff (!por_n)
    (pre_act && !clr_act) |-> state_q);

  // R5
  d_follow_chk: assert property (@(posedge clk_pin) disable iff (!por_n)
    (cfg_clk_sel && cfg_ff_type == 2'b00 && !pre_act && !clr_act)
    |=> (!cfg_clk_sel || pre_act || clr_act || state_q == $past(d_in)));

  // R4
  reg_path_chk: assert property (@(posedge clk_pin) disable iff (!por_n)
    cfg_use_reg |-> pin_out == state_q);

  // R1
  borrow_prim_chk: assert property (@(posedge clk_pin) disable iff (!por_n)
    (|(brw_pt & brw_lent & cfg_brw_en & ~cfg_brw_sec)) |-> prim_raw);
endmodule

bind pld_out_cell pld_out_cell_chk #(.BRW_PT(BRW_PT)) u_chk (
  .clk_pin     (clk_pin),
  .por_n       (por_n),
  .cfg_clk_sel (cfg_clk_sel),
  .cfg_ff_type (cfg_ff_type),
  .cfg_use_reg (cfg_use_reg),
  .pin_out     (pin_out),
  .d_in        (d_in),
  .state_q     (state_q),
  .pre_act     (pre_act),
  .clr_act     (clr_act),
  .prim_raw    (prim_raw),
  .brw_pt      (brw_pt),
  .brw_lent    (brw_lent),
  .cfg_brw_en  (cfg_brw_en),
  .cfg_brw_sec (cfg_brw_sec)
);

// File: tb/tb_pld_out_cell.sv
`timescale 1ns/1ps
module tb_pld_out_cell;
  localparam int NP = 3;
  localparam int BP = 6;
  localparam int CP = 2;

  logic          clk = 1'b0;
  logic          por_n;
  logic [NP-1:0] native_pt;
  logic [BP-1:0] brw_pt, brw_lent, cfg_brw_en, cfg_brw_sec;
  logic          cfg_inv, cfg_use_reg, cfg_clk_sel, clk_pt, pre_pt, cfg_pre_en;
  logic [1:0]    cfg_ff_type;
  logic [CP-1:0] clr_pt, cfg_clr_en;
  logic          pin_out, fb_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit m_q     = 1'b0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pld_out_cell dut (
    .clk_pin(clk), .por_n(por_n), .native_pt(native_pt), .brw_pt(brw_pt),
    .brw_lent(brw_lent), .cfg_brw_en(cfg_brw_en), .cfg_brw_sec(cfg_brw_sec),
    .cfg_inv(cfg_inv), .cfg_use_reg(cfg_use_reg), .cfg_ff_type(cfg_ff_type),
    .cfg_clk_sel(cfg_clk_sel), .clk_pt(clk_pt), .pre_pt(pre_pt),
    .cfg_pre_en(cfg_pre_en), .clr_pt(clr_pt), .cfg_clr_en(cfg_clr_en),
    .pin_out(pin_out), .fb_out(fb_out)
  );

  // ---- reference model ----
  function automatic bit m_sum(input bit want_sec);
    bit s = 0;
    if (!want_sec) for (int i = 0; i < NP; i++) if (native_pt[i]) s = 1;
    for (int i = 0; i < BP; i++)
      if (brw_pt[i] && brw_lent[i] && cfg_brw_en[i] && (cfg_brw_sec[i] == want_sec)) s = 1;
    return s;
  endfunction

  function automatic bit m_a();
    return cfg_inv ? !m_sum(0) : m_sum(0);
  endfunction

  function automatic bit m_step(input bit q);
    bit a = m_a();
    bit b = m_sum(1);
    int t = int'(cfg_ff_type);
    if (t == 0) return a;
    if (t == 1) return a ? !q : q;
    if (t == 2) begin
      if (a && b) return !q;
      if (a) return 1;
      if (b) return 0;
      return q;
    end
    if (a && !b) return 1;
    if (b && !a) return 0;
    return q;
  endfunction

  function automatic bit m_pin();
    return cfg_use_reg ? m_q : m_a();
  endfunction

  // model follows the pin clock when that source is selected
  always @(posedge clk) if (por_n && cfg_clk_sel) m_q <= m_step(m_q);

  task automatic chk(input string req, input bit act, input bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_pin(input string req);
    chk(req, pin_out, m_pin());
    chk("R4", fb_out, pin_out);
  endtask

  task automatic rand_terms();
    native_pt   = NP'($urandom);
    brw_pt      = BP'($urandom);
    brw_lent    = BP'($urandom);
    cfg_brw_en  = BP'($urandom);
    cfg_brw_sec = BP'($urandom);
    if (($urandom % 3) == 0) native_pt = '0;
  endtask

  task automatic pt_clock_pulse();
    #1 clk_pt = 1'b1;
    m_q = m_step(m_q);
    #0.5 clk_pt = 1'b0;
    #0.5;
  endtask

  initial begin
    por_n = 0; native_pt = '0; brw_pt = '0; brw_lent = '0; cfg_brw_en = '0;
    cfg_brw_sec = '0; cfg_inv = 0; cfg_use_reg = 1; cfg_ff_type = 2'b00;
    cfg_clk_sel = 1; clk_pt = 0; pre_pt = 0; cfg_pre_en = 0; clr_pt = '0; cfg_clr_en = '0;
    native_pt = '1;
    repeat (3) @(negedge clk);
    chk("R12", pin_out, 1'b0);
    native_pt = '0;
    por_n = 1;

    // combinational path: sums, borrowing and polarity
    cfg_use_reg = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      rand_terms();
      cfg_inv = k[0];
      #1;
      chk_pin(k[0] ? "R3" : "R1");
    end
    // lent but not enabled, and enabled but not lent: ignored
    @(negedge clk);
    native_pt = '0; brw_pt = '1; cfg_brw_sec = '0; cfg_inv = 0;
    brw_lent = 6'b101010; cfg_brw_en = 6'b010101;
    #1 chk("R1", pin_out, 1'b0);
    // terms routed to the secondary sum never reach the primary sum
    brw_lent = '1; cfg_brw_en = '1; cfg_brw_sec = '1;
    #1 chk("R2", pin_out, 1'b0);

    // registered path: every flop type against the model on the pin clock
    cfg_use_reg = 1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      cfg_ff_type = 2'(t);
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        chk_pin(t == 0 ? "R5" : t == 1 ? "R6" : t == 2 ? "R7" : "R8");
        rand_terms();
        cfg_inv = 1'($urandom);
      end
      @(negedge clk);
      chk_pin(t == 0 ? "R5" : t == 1 ? "R6" : t == 2 ? "R7" : "R8");
    end

    // move to the product-term clock while both clocks are low
    @(negedge clk);
    cfg_clk_sel = 0; cfg_ff_type = 2'b00; cfg_inv = 0;
    brw_pt = '0; native_pt = 3'b001;
    @(posedge clk); #1;
    chk("R9", pin_out, m_q);
    @(negedge clk);
    pt_clock_pulse();
    chk("R9", pin_out, 1'b1);
    native_pt = '0;
    @(posedge clk); #1;
    chk("R9", pin_out, 1'b1);
    @(negedge clk);
    pt_clock_pulse();
    chk("R9", pin_out, 1'b0);

    // secondary sum resets in SR mode
    cfg_ff_type = 2'b11;
    cfg_pre_en = 1; pre_pt = 1; #0.5 m_q = 1; pre_pt = 0;
    #0.5 chk("R10", pin_out, 1'b1);
    brw_pt = 6'b000100; brw_lent = '1; cfg_brw_en = '1; cfg_brw_sec = 6'b000100;
    pt_clock_pulse();
    chk("R2", pin_out, 1'b0);
    brw_pt = '0;

    // preset masked by its enable
    @(negedge clk);
    cfg_pre_en = 0; #1 pre_pt = 1; #0.5;
    chk("R10", pin_out, 1'b0);
    pre_pt = 0;
    // preset then masked clear term, then enabled second clear term
    cfg_pre_en = 1; pre_pt = 1; m_q = 1; #0.5 pre_pt = 0;
    cfg_clr_en = 2'b01; clr_pt = 2'b10; #0.5;
    chk("R11", pin_out, 1'b1);
    clr_pt = 2'b00; cfg_clr_en = 2'b10; #0.2 clr_pt = 2'b10; m_q = 0; #0.5;
    chk("R11", pin_out, 1'b0);
    clr_pt = 2'b00;
    // preset and clear together: clear wins
    @(negedge clk);
    #1 pre_pt = 1; clr_pt = 2'b10; m_q = 0; #0.5;
    chk("R11", pin_out, 1'b0);
    clr_pt = 2'b00; pre_pt = 0; #0.5;
    chk("R11", pin_out, 1'b0);

    // back on the pin clock in JK mode, toggle with J=K=1
    @(negedge clk);
    cfg_clk_sel = 1; cfg_ff_type = 2'b10; native_pt = 3'b100;
    brw_pt = 6'b000001; brw_lent = '1; cfg_brw_en = '1; cfg_brw_sec = 6'b000001;
    @(negedge clk); chk("R7", pin_out, 1'b1);
    @(negedge clk); chk("R7", pin_out, 1'b0);
    chk_pin("R9");

    // reset reasserted clears the state
    native_pt = 3'b111; brw_pt = '0; cfg_ff_type = 2'b00;
    @(negedge clk); chk("R5", pin_out, 1'b1);
    por_n = 0; m_q = 0; #1;
    chk("R12", pin_out, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule